// File: doc/BRIEF.md
# Serial Audio Capture Transmit Port (Slave)

This block sends captured stereo audio out of a chip over a serial data line, with the far end providing the timing. The far end drives a bit clock and a left/right frame clock. The block sends each 24-bit signed left and right sample as a serial word, most significant bit first. A word can be 16, 20, 24 or 32 bits long. Four framing formats set where the word sits relative to the frame clock.

Both pins are oversampled by the local clock `clk` through a synchronizer. The block launches data on the active-falling edge of the bit clock, and a configuration bit can invert which pin edge that is. One word-length setting serves the whole interface. Both samples of a frame are captured when the frame starts, so a sample that changes later cannot corrupt the word in flight. The data line is always driven. It is low in reset, in standby and in every bit period that carries no word bit.

Top module: `audio_ser_tx`

## Requirements
- R1: `sdata_out` is 0 while `rst_n` is low and stays 0 after reset until a word bit is launched.
- R2: With `wlen_sel` 00 (16 bits) or 01 (20 bits), the word is the top 16 or 20 bits of the sample, MSB first, and the low bits are dropped. `wlen_sel` 10 sends all 24 bits.
- R3: With `wlen_sel` 11 (32 bits), the 24 sample bits are followed by 8 zero bits.
- R4: `sdata_out` changes only in response to an active-falling bit clock edge, three `clk` rising edges after the pin change. A rising edge never changes it.
- R5: `fmt_sel` 01 (left justified): the word MSB occupies the bit period that begins at the frame clock change. Frame clock high carries left and low carries right.
- R6: `fmt_sel` 10 (I2S): the MSB occupies the bit period after the frame clock change. Frame clock low carries left and high carries right.
- R7: `fmt_sel` 00 (right justified): the word LSB occupies the last bit period before the frame clock changes. Frame clock high carries left. The half-frame length is measured on the previous half. Until one full half has been measured, the output stays low.
- R8: `fmt_sel` 11 (DSP): a rising frame clock starts a frame. The left MSB follows one bit period later, and the right word follows the left LSB with no gap.
- R9: With `bclk_inv` 1, the rising pin edge of `bclk_in` takes the role of the falling edge.
- R10: In every bit period that carries no word bit, `sdata_out` is 0.
- R11: While `standby` is high, `sdata_out` is forced low from the next `clk` edge. Framing state is cleared, including the right-justified length measurement.
- R12: Both samples are captured at the frame clock edge that starts a frame (rising for formats 00, 01 and 11, falling for 10). Input changes after that edge do not affect the words of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Forces the output low and clears framing state |
| fmt_sel | input | 2 | Framing format: 00 right justified, 01 left justified, 10 I2S, 11 DSP |
| wlen_sel | input | 2 | Word length: 00=16, 01=20, 10=24, 11=32 bits |
| bclk_inv | input | 1 | Inverts the bit clock pin interpretation |
| bclk_in | input | 1 | Bit clock from the far end |
| lrclk_in | input | 1 | Left/right frame clock from the far end |
| left_in | input | 24 | Left sample, signed two's complement |
| right_in | input | 24 | Right sample, signed two's complement |
| sdata_out | output | 1 | Serial data output |

## Verification
A pin edge passes two synchronizer flops and one edge-detect flop, so a launched bit reaches `sdata_out` at the third `clk` rising edge after the active bit clock edge. The bench keeps each bit clock level for four `clk` cycles. It reads the data line once three cycles after the falling edge and again three cycles after the rising edge, and both reads must equal the bit predicted for that period, which also shows that the rising edge changes nothing. Standby takes effect one `clk` edge after it rises, and the bench checks the line two cycles later.

// File: rtl/stx_pkg.sv
package stx_pkg;

  localparam int SLOT_W = 32;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  function automatic logic [5:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      2'b10:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/stx_pin_sync.sv
module stx_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_pin,
  input  logic lr_pin,
  input  logic bclk_inv,
  output logic bclk_fall,
  output logic lr_level
);

  logic [STAGES-1:0] bck_sr_q, bck_sr_d;
  logic [STAGES-1:0] lr_sr_q, lr_sr_d;
  logic              eff_q, eff_now;

  always_comb begin
    bck_sr_d  = {bck_sr_q[STAGES-2:0], bclk_pin};
    lr_sr_d   = {lr_sr_q[STAGES-2:0], lr_pin};
    eff_now   = bck_sr_q[STAGES-1] ^ bclk_inv;
    bclk_fall = eff_q & ~eff_now;
    lr_level  = lr_sr_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_sr_q <= '0;
      lr_sr_q  <= '0;
      eff_q    <= 1'b0;
    end else begin
      bck_sr_q <= bck_sr_d;
      lr_sr_q  <= lr_sr_d;
      eff_q    <= eff_now;
    end
  end

endmodule

// File: rtl/stx_frame_track.sv
module stx_frame_track
  import stx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bclk_fall,
  input  logic             lr_level,
  input  fmt_e             fmt,
  output logic [CNT_W-1:0] pos_now,
  output logic [CNT_W-1:0] half_len,
  output logic             frame_start
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] pos_q, pos_inc, half_q, half_d;
  logic             lr_prev_q, seen_q, seen_d;
  logic             lr_edge, restart;

  always_comb begin
    lr_edge     = bclk_fall && (lr_level != lr_prev_q);
    restart     = (fmt == FMT_DSP) ? (lr_edge && lr_level) : lr_edge;
    pos_inc     = (pos_q == CNT_MAX) ? pos_q : pos_q + CNT_W'(1);
    pos_now     = restart ? '0 : pos_inc;
    frame_start = lr_edge && ((fmt == FMT_I2S) ? !lr_level : lr_level);
    seen_d      = seen_q | lr_edge;
    half_d      = (lr_edge && seen_q) ? pos_inc : half_q;
    half_len    = half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      half_q    <= '0;
      lr_prev_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (clr) begin
      pos_q     <= '0;
      half_q    <= '0;
      lr_prev_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (bclk_fall) begin
      pos_q     <= pos_now;
      half_q    <= half_d;
      lr_prev_q <= lr_level;
      seen_q    <= seen_d;
    end
  end

endmodule

// File: rtl/stx_bit_pick.sv
module stx_bit_pick
  import stx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  fmt_e                fmt,
  input  logic [1:0]          wlen_sel,
  input  logic [CNT_W-1:0]    pos,
  input  logic [CNT_W-1:0]    half_len,
  input  logic                lr_level,
  input  logic [SAMPLE_W-1:0] left_w,
  input  logic [SAMPLE_W-1:0] right_w,
  output logic                bit_val,
  output logic                in_word,
  output logic [CNT_W:0]      slot_idx
);

  localparam int IW = CNT_W + 1;
  localparam int KW = $clog2(SLOT_W);

  logic [SLOT_W-1:0] vec_l, vec_r;
  logic [IW-1:0]     n, p, h, k;
  logic [KW-1:0]     idx;
  logic              use_left;

  generate
    if (SLOT_W > SAMPLE_W) begin : g_pad
      assign vec_l = {left_w,  {(SLOT_W-SAMPLE_W){1'b0}}};
      assign vec_r = {right_w, {(SLOT_W-SAMPLE_W){1'b0}}};
    end else begin : g_trim
      assign vec_l = left_w[SAMPLE_W-1 -: SLOT_W];
      assign vec_r = right_w[SAMPLE_W-1 -: SLOT_W];
    end
  endgenerate

  always_comb begin
    n        = IW'(word_bits(wlen_sel));
    p        = {1'b0, pos};
    h        = {1'b0, half_len};
    k        = p;
    in_word  = 1'b0;
    use_left = 1'b1;
    case (fmt)
      FMT_LJ: begin
        k        = p;
        in_word  = (p < n);
        use_left = lr_level;
      end
      FMT_I2S: begin
        k        = p - IW'(1);
        in_word  = (p != '0) && (k < n);
        use_left = !lr_level;
      end
      FMT_RJ: begin
        k        = p + n - h;
        in_word  = (p < h) && ((p + n) >= h);
        use_left = lr_level;
      end
      default: begin
        k = p - IW'(1);
        if (p != '0) begin
          if (k < n) begin
            in_word = 1'b1;
          end else if (k < (n << 1)) begin
            in_word  = 1'b1;
            use_left = 1'b0;
            k        = k - n;
          end
        end
      end
    endcase
    idx      = KW'(SLOT_W-1) - k[KW-1:0];
    bit_val  = in_word & (use_left ? vec_l[idx] : vec_r[idx]);
    slot_idx = k;
  end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import stx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  input  logic                bclk_inv,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sdata_out
);

  fmt_e                fmt;
  logic                fall, lr_level, frame_start;
  logic [CNT_W-1:0]    pos_now, half_len;
  logic [SAMPLE_W-1:0] lsh_q, rsh_q, lsel, rsel;
  logic                shadow_en;
  logic                pick_bit, pick_win;
  logic [CNT_W:0]      pick_k;
  logic                sdata_q, sdata_d;

  assign fmt = fmt_e'(fmt_sel);

  stx_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_pin(bclk_in), .lr_pin(lrclk_in),
    .bclk_inv(bclk_inv), .bclk_fall(fall), .lr_level(lr_level)
  );

  stx_frame_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(standby), .bclk_fall(fall),
    .lr_level(lr_level), .fmt(fmt), .pos_now(pos_now),
    .half_len(half_len), .frame_start(frame_start)
  );

  stx_bit_pick #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_pick (
    .fmt(fmt), .wlen_sel(wlen_sel), .pos(pos_now), .half_len(half_len),
    .lr_level(lr_level), .left_w(lsel), .right_w(rsel),
    .bit_val(pick_bit), .in_word(pick_win), .slot_idx(pick_k)
  );

  always_comb begin
    lsel      = frame_start ? left_in  : lsh_q;
    rsel      = frame_start ? right_in : rsh_q;
    shadow_en = frame_start && !standby;
    if (standby)   sdata_d = 1'b0;
    else if (fall) sdata_d = pick_bit;
    else           sdata_d = sdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsh_q <= '0;
      rsh_q <= '0;
    end else if (shadow_en) begin
      lsh_q <= left_in;
      rsh_q <= right_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdata_q <= 1'b0;
    else        sdata_q <= sdata_d;
  end

  assign sdata_out = sdata_q;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                standby,
  input logic [1:0]          wlen_sel,
  input logic                sdata_out,
  input logic                fall,
  input logic                frame_start,
  input logic                pick_win,
  input logic [CNT_W:0]      pick_k,
  input logic [SAMPLE_W-1:0] lsh_q,
  input logic [SAMPLE_W-1:0] rsh_q
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_low: assert (sdata_out == 1'b0);
    end
  end

  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_out) |-> ($past(fall) || $past(standby)));

  a_r11_standby_low: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !sdata_out);

  a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !standby && pick_win && wlen_sel == 2'b11 && pick_k >= (CNT_W+1)'(SAMPLE_W))
    |=> !sdata_out);

  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !standby && !pick_win) |=> !sdata_out);

  a_r12_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lsh_q) |-> $past(frame_start));

  a_r12_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsh_q) |-> $past(frame_start));

endmodule

bind audio_ser_tx audio_ser_tx_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .wlen_sel(wlen_sel),
  .sdata_out(sdata_out), .fall(fall), .frame_start(frame_start),
  .pick_win(pick_win), .pick_k(pick_k), .lsh_q(lsh_q), .rsh_q(rsh_q)
);

// File: tb/audio_ser_tx_test.sv
module audio_ser_tx_test;

  logic        clk;
  logic        rst_n;
  logic        standby;
  logic [1:0]  fmt_sel;
  logic [1:0]  wlen_sel;
  logic        bclk_inv;
  logic        bclk_in;
  logic        lrclk_in;
  logic [23:0] left_in;
  logic [23:0] right_in;
  logic        sdata_out;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  audio_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .fmt_sel(fmt_sel),
    .wlen_sel(wlen_sel), .bclk_inv(bclk_inv), .bclk_in(bclk_in),
    .lrclk_in(lrclk_in), .left_in(left_in), .right_in(right_in),
    .sdata_out(sdata_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp, input int at);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0d: actual=%b expected=%b", tag, at, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] s);
    case (s)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic slot_bit(input logic [23:0] smp, input int k, input int n);
    logic [31:0] v;
    v = {smp, 8'h00};
    if (k < 0 || k >= n) return 1'b0;
    return v[31-k];
  endfunction

  // one bit period: active fall, 4 clk low, rise, 4 clk high
  task automatic bit_cycle(input logic lr, output logic s_early, output logic s_late);
    @(negedge clk);
    bclk_in  = 1'b0 ^ bclk_inv;
    lrclk_in = lr;
    repeat (3) @(negedge clk);
    s_early = sdata_out;
    @(negedge clk);
    bclk_in = 1'b1 ^ bclk_inv;
    repeat (3) @(negedge clk);
    s_late = sdata_out;
  endtask

  task automatic setup(input logic [1:0] f, input logic [1:0] ws, input logic inv,
                       input logic [23:0] l0, input logic [23:0] r0);
    logic a, b;
    fmt_sel  = f;
    wlen_sel = ws;
    bclk_inv = inv;
    bclk_in  = 1'b1 ^ inv;
    lrclk_in = (f == 2'b10);
    left_in  = l0;
    right_in = r0;
    repeat (4) @(negedge clk);
    standby = 1'b1;
    repeat (2) @(negedge clk);
    standby = 1'b0;
    repeat (2) bit_cycle(f == 2'b10, a, b);
  endtask

  task automatic run_case(input string tag, input logic [1:0] f, input logic [1:0] ws,
                          input logic inv, input int h, input int nfr,
                          input logic [23:0] l0, input logic [23:0] r0, input logic mid);
    int n, k, meas;
    logic se, sl, ex, first, lr;
    logic [23:0] el, er;
    n = wbits(ws);
    setup(f, ws, inv, l0, r0);
    first = (f != 2'b10);
    for (int fr = 0; fr < nfr; fr++) begin
      el = left_in;
      er = right_in;
      if (f == 2'b11) begin
        for (int b = 0; b < h; b++) begin
          bit_cycle(b == 0, se, sl);
          k = b - 1;
          if (b == 0)      ex = 1'b0;
          else if (k < n)  ex = slot_bit(el, k, n);
          else             ex = slot_bit(er, k - n, n);
          chk({tag, " R4 early"}, se, ex, fr*1000 + b);
          chk(tag, sl, ex, fr*1000 + b);
          if (mid && fr == 0 && b == 5) begin left_in = ~l0; right_in = ~r0; end
        end
      end else begin
        for (int hf = 0; hf < 2; hf++) begin
          meas = (fr == 0 && hf == 0) ? 0 : h;
          for (int p = 0; p < h; p++) begin
            lr = (hf == 0) ? first : !first;
            bit_cycle(lr, se, sl);
            case (f)
              2'b01:   k = p;
              2'b10:   k = p - 1;
              default: k = (meas == 0) ? -1 : p - (meas - n);
            endcase
            ex = slot_bit((hf == 0) ? el : er, k, n);
            chk({tag, " R4 early"}, se, ex, fr*1000 + hf*100 + p);
            chk(tag, sl, ex, fr*1000 + hf*100 + p);
            if (mid && fr == 0 && hf == 0 && p == 3) begin left_in = ~l0; right_in = ~r0; end
          end
        end
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 in reset", sdata_out, 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", sdata_out, 1'b0, 1);
  endtask

  task automatic t_left_just;
    run_case("R5 R10 lj24", 2'b01, 2'b10, 1'b0, 32, 2, 24'hA5F00F, 24'h3C1234, 1'b0);
  endtask

  task automatic t_i2s_short;
    run_case("R6 R2 i2s16", 2'b10, 2'b00, 1'b0, 32, 2, 24'hC3A55A, 24'h5A0FF1, 1'b0);
    run_case("R6 R2 i2s20", 2'b10, 2'b01, 1'b0, 24, 1, 24'h9ABCDE, 24'h7F00F3, 1'b0);
  endtask

  task automatic t_pad32;
    run_case("R3 lj32", 2'b01, 2'b11, 1'b0, 32, 1, 24'hFFFFFF, 24'hFFFFFF, 1'b0);
  endtask

  task automatic t_right_just;
    run_case("R7 R11 rj24", 2'b00, 2'b10, 1'b0, 40, 2, 24'hB1C2D3, 24'h8E7F61, 1'b0);
    run_case("R7 R2 rj16", 2'b00, 2'b00, 1'b0, 32, 2, 24'h13579B, 24'hECA864, 1'b0);
  endtask

  task automatic t_dsp;
    run_case("R8 R10 dsp24", 2'b11, 2'b10, 1'b0, 56, 2, 24'hD00D5F, 24'h6B3E21, 1'b0);
  endtask

  task automatic t_invert;
    run_case("R9 lj24 inverted", 2'b01, 2'b10, 1'b1, 32, 1, 24'h5AC3E7, 24'hA1B2C3, 1'b0);
  endtask

  task automatic t_mid_change;
    run_case("R12 lj24 mid", 2'b01, 2'b10, 1'b0, 32, 2, 24'hF0F0F0, 24'h0FF00F, 1'b1);
    run_case("R12 dsp16 mid", 2'b11, 2'b00, 1'b0, 40, 2, 24'h8001FF, 24'hFF8001, 1'b1);
  endtask

  task automatic t_standby;
    logic se, sl;
    setup(2'b01, 2'b10, 1'b0, 24'hFFFFFF, 24'hFFFFFF);
    for (int b = 0; b < 3; b++) bit_cycle(1'b1, se, sl);
    chk("R11 line high before", sl, 1'b1, 0);
    standby = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 forced low", sdata_out, 1'b0, 1);
    standby = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 low after release", sdata_out, 1'b0, 2);
  endtask

  initial begin
    rst_n    = 1'b0;
    standby  = 1'b0;
    fmt_sel  = 2'b01;
    wlen_sel = 2'b10;
    bclk_inv = 1'b0;
    bclk_in  = 1'b1;
    lrclk_in = 1'b0;
    left_in  = '0;
    right_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_left_just();
    t_i2s_short();
    t_pad32();
    t_right_just();
    t_dsp();
    t_invert();
    t_mid_change();
    t_standby();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule